// File: doc/BRIEF.md
# UART Transmit Channel

This block is one asynchronous serial transmit channel. A byte written through a data port is framed and sent on a single output line. Each frame is a start bit, eight data bits, an optional parity bit and one or two stop bits. Each bit lasts a fixed number of baud ticks. The ticks come from one of two external prescaler outputs, chosen by a select input.

A one-entry holding register sits in front of the shifter. Software can queue the next byte while the current frame is still on the line. When that frame ends, the queued byte follows with no idle gap. Configuration inputs set the following:

- parity mode
- stop length
- bit order
- line polarity
- which event raises the interrupt pulse

Each frame uses the configuration sampled at its start bit.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset, `tx_out` is at the idle level (1 when `inv_out` is 0), and `busy`, `irq` and `overrun` are all 0.
- R2: A frame starts with a 0 start bit, then carries eight data bits taken from `wr_data[7:0]` (the upper bits are ignored), then its stop bits at 1. Every bit holds for OVS ticks of the selected tick source.
- R3: When `lsb_first` is 0, the data goes out MSB first. When it is 1, the data goes out LSB first.
- R4: `par_mode` selects the parity bit, which is sent after the data:
  - 00 sends no parity bit.
  - 01 sends a parity bit that is always 0.
  - 10 sends even parity over the eight data bits.
  - 11 sends odd parity over the eight data bits.
- R5: `stop_mode` 10 sends two stop bits. Every other code sends one stop bit.
- R6: When `inv_out` is 1, the whole line waveform is inverted, including the idle level.
- R7: When `clk_sel` is 0, bit timing counts `tick_src0`. When it is 1, bit timing counts `tick_src1`.
- R8: A byte written while a frame is active is held. Its start bit follows the last stop bit of the current frame with no idle cycle in between. A byte written when the channel is idle starts its frame two cycles after the write.
- R9: A write while the holding register is full, and the register is not handing its byte to the shifter in that same cycle, is ignored. That write sets `overrun`, which stays set until reset.
- R10: `busy` is 1 whenever a frame is on the line or a byte is held, and 0 otherwise.
- R11: When `irq_sel` is 0, `irq` pulses for one cycle in the cycle after a frame's last stop bit ends. When `irq_sel` is 1, it pulses for one cycle in the cycle after a held byte moves into the shifter.
- R12: Changes to `par_mode`, `stop_mode`, `lsb_first` and `inv_out` made during a frame do not affect that frame. They apply from the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src0 | input | 1 | Prescaler tick, source 0 |
| tick_src1 | input | 1 | Prescaler tick, source 1 |
| clk_sel | input | 1 | Tick source select |
| par_mode | input | 2 | Parity mode code |
| stop_mode | input | 2 | Stop length code |
| lsb_first | input | 1 | Bit order select |
| inv_out | input | 1 | Line inversion |
| irq_sel | input | 1 | Interrupt event select |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | BUS_W | Write data; the low 8 bits are the byte |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | Frame active or byte held |
| irq | output | 1 | Interrupt pulse |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the channel with OVS=4, DATA_W=8 and BUS_W=16. The short bit period lets a few thousand cycles cover every parity code, every stop code, both bit orders, and both polarities. It also covers back-to-back frames, an overrun and a mid-frame configuration change. The two tick sources run at one tick in two cycles and one tick in three, so a wrong source select changes every bit length. The write data carries nonzero upper bits to show they are dropped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    localparam logic [1:0] STOP_TWO = 2'b10;

    typedef struct packed {
        par_e       par;
        logic [1:0] stop;
        logic       lsb_first;
        logic       inv;
    } cfg_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_src0,
    input  logic tick_src1,
    input  logic clk_sel,
    input  logic run,
    input  logic restart,
    output logic bit_end
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic          tick;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick    = clk_sel ? tick_src1 : tick_src0;
        bit_end = run && tick && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // bit timing restarts after every bit boundary
    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              overrun
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              ovr;
    } hb_t;

    hb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.valid = 1'b0;
        if (wr_en) begin
            if (!st_q.valid || take) begin
                st_d.valid = 1'b1;
                st_d.data  = wr_byte;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid   = st_q.valid;
    assign data    = st_q.data;
    assign overrun = st_q.ovr;

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid && !take) |=> ($stable(data) && overrun));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  cfg_t              cfg_in,
    output logic              take,
    output logic              done,
    output logic              active,
    output logic              line_bit,
    output logic              inv_lat
);
    localparam int IW = $clog2(DATA_W + 4);
    localparam logic [IW-1:0] DATA_LAST = IW'(DATA_W);
    localparam logic [IW-1:0] PAR_IDX   = IW'(DATA_W + 1);

    typedef struct packed {
        logic              active;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sh;
        logic              par_bit;
        cfg_t              cfg;
    } ser_t;

    ser_t              st_d, st_q;
    logic [IW-1:0]     last_idx;
    logic              frame_end;
    logic [DATA_W-1:0] rev;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) rev[i] = hold_data[DATA_W-1-i];
    end

    always_comb begin
        last_idx = DATA_LAST
                 + ((st_q.cfg.par != PAR_NONE) ? IW'(1) : IW'(0))
                 + ((st_q.cfg.stop == STOP_TWO) ? IW'(2) : IW'(1));
        frame_end = st_q.active && bit_end && (st_q.idx == last_idx);
        take      = hold_valid && (!st_q.active || frame_end);
        done      = frame_end;

        st_d = st_q;
        if (frame_end) begin
            st_d.active = 1'b0;
        end else if (st_q.active && bit_end) begin
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx != '0 && st_q.idx <= DATA_LAST)
                st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
        end
        if (take) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.cfg    = cfg_in;
            st_d.sh     = cfg_in.lsb_first ? rev : hold_data;
            case (cfg_in.par)
                PAR_EVEN: st_d.par_bit = ^hold_data;
                PAR_ODD:  st_d.par_bit = ~^hold_data;
                default:  st_d.par_bit = 1'b0;
            endcase
        end

        if (st_q.idx == '0)
            line_bit = 1'b0;
        else if (st_q.idx <= DATA_LAST)
            line_bit = st_q.sh[DATA_W-1];
        else if (st_q.idx == PAR_IDX && st_q.cfg.par != PAR_NONE)
            line_bit = st_q.par_bit;
        else
            line_bit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign inv_lat = st_q.cfg.inv;

    // a frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (active && line_bit == 1'b0));

endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 16,
    parameter int OVS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_src0,
    input  logic             tick_src1,
    input  logic             clk_sel,
    input  logic [1:0]       par_mode,
    input  logic [1:0]       stop_mode,
    input  logic             lsb_first,
    input  logic             inv_out,
    input  logic             irq_sel,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic             tx_out,
    output logic             busy,
    output logic             irq,
    output logic             overrun
);
    typedef struct packed {
        logic irq;
    } top_t;

    top_t              st_d, st_q;
    cfg_t              cfg_in;
    logic              bit_end, take, done, active, line_bit, inv_lat;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;

    assign cfg_in = '{par: par_e'(par_mode), stop: stop_mode,
                      lsb_first: lsb_first, inv: inv_out};

    uart_tx_baud #(.OVS(OVS)) u_baud (
        .clk(clk), .rst_n(rst_n), .tick_src0(tick_src0), .tick_src1(tick_src1),
        .clk_sel(clk_sel), .run(active), .restart(take), .bit_end(bit_end)
    );

    uart_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_data[DATA_W-1:0]),
        .take(take), .valid(hold_valid), .data(hold_data), .overrun(overrun)
    );

    uart_tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .hold_valid(hold_valid),
        .hold_data(hold_data), .cfg_in(cfg_in), .take(take), .done(done),
        .active(active), .line_bit(line_bit), .inv_lat(inv_lat)
    );

    always_comb begin
        st_d.irq = irq_sel ? take : done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_out = active ? (line_bit ^ inv_lat) : ~inv_out;
    assign busy   = active || hold_valid;
    assign irq    = st_q.irq;

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_out == !inv_out));

endmodule

// File: tb/sim_uart_tx_chan.sv
module sim_uart_tx_chan;
    localparam int OVS   = 4;
    localparam int BUS_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_src0 = 1'b0, tick_src1 = 1'b0, clk_sel = 1'b0;
    logic [1:0]       par_mode = 2'b00, stop_mode = 2'b01;
    logic             lsb_first = 1'b0, inv_out = 1'b0, irq_sel = 1'b0;
    logic             wr_en = 1'b0;
    logic [BUS_W-1:0] wr_data = '0;
    logic             tx_out, busy, irq, overrun;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R2";
    bit    cmp_on = 1'b0;

    always #4 clk = ~clk;

    uart_tx_chan #(.DATA_W(8), .BUS_W(BUS_W), .OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_src0(tick_src0), .tick_src1(tick_src1),
        .clk_sel(clk_sel), .par_mode(par_mode), .stop_mode(stop_mode),
        .lsb_first(lsb_first), .inv_out(inv_out), .irq_sel(irq_sel),
        .wr_en(wr_en), .wr_data(wr_data), .tx_out(tx_out), .busy(busy),
        .irq(irq), .overrun(overrun)
    );

    // tick sources: one in two cycles and one in three cycles
    initial begin
        int n = 0;
        forever begin
            @(posedge clk); #5;
            tick_src0 = (n % 2 == 0);
            tick_src1 = (n % 3 == 0);
            n++;
        end
    end

    // behavioural reference model
    bit         m_bits[$];
    logic [7:0] m_hold[$];
    bit         m_active = 0, m_ovr = 0, m_irq = 0, m_inv = 0;
    int         m_sub = 0;

    function automatic void build_frame(input logic [7:0] d, input logic [1:0] pm,
                                        input logic [1:0] sm, input logic lf);
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_bits.push_back(lf ? d[i] : d[7-i]);
        if (pm == 2'b01) m_bits.push_back(1'b0);
        if (pm == 2'b10) m_bits.push_back(^d);
        if (pm == 2'b11) m_bits.push_back(~^d);
        m_bits.push_back(1'b1);
        if (sm == 2'b10) m_bits.push_back(1'b1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits.delete(); m_hold.delete();
            m_active = 0; m_ovr = 0; m_irq = 0; m_sub = 0; m_inv = 0;
        end else begin
            bit tk, hold_old, tk_take, tk_done;
            logic [7:0] d;
            tk = clk_sel ? tick_src1 : tick_src0;
            hold_old = (m_hold.size() != 0);
            tk_take = 0; tk_done = 0;
            if (m_active && tk) begin
                if (m_sub == OVS - 1) begin
                    m_sub = 0;
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) begin tk_done = 1; m_active = 0; end
                end else m_sub++;
            end
            if (!m_active && hold_old) begin
                tk_take = 1;
                d = m_hold.pop_front();
                build_frame(d, par_mode, stop_mode, lsb_first);
                m_active = 1; m_sub = 0; m_inv = inv_out;
            end
            if (wr_en) begin
                if (!hold_old || tk_take) m_hold.push_back(wr_data[7:0]);
                else m_ovr = 1;
            end
            m_irq = irq_sel ? tk_take : tk_done;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (cmp_on) begin
                check(cur_req, "tx_out", tx_out, m_active ? (m_bits[0] ^ m_inv) : ~inv_out);
                check("R10", "busy", busy, m_active || (m_hold.size() != 0));
                check("R11", "irq", irq, m_irq);
                check("R9", "overrun", overrun, m_ovr);
            end
        end
    end

    task automatic write_byte(input logic [BUS_W-1:0] v);
        @(posedge clk); #5;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #5;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (m_active || m_hold.size() != 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", "idle tx_out", tx_out, 1'b1);
        check("R1", "busy", busy, 1'b0);
        check("R1", "irq", irq, 1'b0);
        check("R1", "overrun", overrun, 1'b0);
        cmp_on = 1'b1;

        cur_req = "R2"; write_byte(16'hA5C3); wait_idle();
        cur_req = "R3"; @(posedge clk); #5 lsb_first = 1; write_byte(16'h00B1); wait_idle();
        @(posedge clk); #5 lsb_first = 0;

        cur_req = "R4";
        for (int p = 1; p < 4; p++) begin
            @(posedge clk); #5 par_mode = 2'(p);
            write_byte(16'h0037); wait_idle();
            write_byte(16'h0036); wait_idle();
        end
        @(posedge clk); #5 par_mode = 0;

        cur_req = "R5";
        @(posedge clk); #5 stop_mode = 2'b10; write_byte(16'h0F5A); wait_idle();
        @(posedge clk); #5 stop_mode = 2'b11; write_byte(16'h005A); wait_idle();
        @(posedge clk); #5 stop_mode = 2'b00; write_byte(16'h0081); wait_idle();
        @(posedge clk); #5 stop_mode = 2'b01;

        cur_req = "R6";
        @(posedge clk); #5 inv_out = 1; wait_cycles(3);
        write_byte(16'h00E7); wait_idle();
        @(posedge clk); #5 inv_out = 0;

        cur_req = "R7";
        @(posedge clk); #5 clk_sel = 1; write_byte(16'h0072); wait_idle();
        @(posedge clk); #5 clk_sel = 0;

        cur_req = "R8";
        write_byte(16'h0011); wait_cycles(20); write_byte(16'h00EE); wait_idle();

        cur_req = "R9";
        write_byte(16'h0021); wait_cycles(4); write_byte(16'h0042); write_byte(16'h0084);
        wait_idle();

        cur_req = "R11";
        @(posedge clk); #5 irq_sel = 1;
        write_byte(16'h0055); wait_cycles(10); write_byte(16'h00AA); wait_idle();
        @(posedge clk); #5 irq_sel = 0;

        cur_req = "R12";
        write_byte(16'h00C6); wait_cycles(12);
        @(posedge clk); #5 par_mode = 2'b11; stop_mode = 2'b10; lsb_first = 1; inv_out = 1;
        wait_idle(); write_byte(16'h00C6); wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule